// File: doc/BRIEF.md
# Display controller power-mode sequencer

This block holds the power state of a small LCD driver controller. Byte commands come in on a write strobe. A select line marks each byte as a command or as data. The block tracks three power states: normal, standby and sleep. It also keeps a test-mode flag. From the current state it drives the enables for the oscillator, the LCD supply, the duty (multiplexed) drive and the static indicator drive. It also drives a flag that forces the segment and common outputs to the VDD level, and an active-low display-off pin. That pin can be used to cut power to external supply circuits, such as a resistive bias divider.

Standby is the lighter saving level: the oscillator keeps running, so the static indicator can stay on. Sleep is the deeper level, with everything halted. If a reset command arrives while the block is in standby, it drops into sleep. The test flag can only be cleared by a no-operation command, a reset command or the hardware reset. Every output is decoded from registered state, so a command is visible on the outputs one clock after the cycle that carries it.

Top module: `lcd_pwr_seq`

## Requirements
- R1: A byte is taken as a command only in a cycle where `cmd_sel`=0, `wr_stb`=1 and `rd_stb`=0. Its effect shows after the next rising clock edge. Data bytes, read cycles and command values not listed below change nothing.
- R2: In normal state (`pwr_state`=00) the outputs are as follows. `osc_en`=1, `duty_en`=1, `force_vdd`=0 and `disp_off_n`=1. `supply_en` follows `supply_req` and `static_en` follows `static_cfg`.
- R3: Command 0xA8 or 0xA9 enters a power-saver state from any state. If bit 0 is 1 the block goes to standby (`pwr_state`=01). If bit 0 is 0 it goes to sleep (`pwr_state`=10).
- R4: In standby the outputs are as follows. `osc_en`=1, `supply_en`=0, `duty_en`=0, `force_vdd`=1 and `disp_off_n`=0. `static_en` follows `static_cfg`.
- R5: In sleep, `osc_en`, `supply_en`, `duty_en` and `static_en` are all 0, `force_vdd`=1 and `disp_off_n`=0.
- R6: Reset command 0xE2 clears the test flag. It moves standby to sleep and leaves normal and sleep unchanged.
- R7: Release command 0xE1 returns the block to normal from any state, which sets `disp_off_n` high again.
- R8: No-operation command 0xE3 leaves the power state unchanged and clears the test flag.
- R9: Any command whose upper nibble is 1111 sets `test_mode`, whatever its lower four bits are. The power state does not change.
- R10: The hardware reset (`rst_n` low) puts the block in normal state with `test_mode`=0. The outputs reach their reset values without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_sel | input | 1 | 0 = byte is a command, 1 = display data |
| wr_stb | input | 1 | Write strobe, one cycle per byte |
| rd_stb | input | 1 | Read strobe; blocks the write when active |
| din | input | 8 | Command byte |
| supply_req | input | 1 | LCD supply requested by the power-control setting |
| static_cfg | input | 1 | Static indicator drive configured on |
| pwr_state | output | 2 | 00 normal, 01 standby, 10 sleep |
| test_mode | output | 1 | Test-mode flag |
| osc_en | output | 1 | Oscillator enable |
| supply_en | output | 1 | LCD supply enable |
| duty_en | output | 1 | Duty drive enable |
| static_en | output | 1 | Static indicator drive enable |
| force_vdd | output | 1 | Force segment and common outputs to VDD |
| disp_off_n | output | 1 | Active-low display-off, low in either power-saver state |

## Verification
The state register feeds every output directly, so a wrong internal state shows on the ports one clock after the command that caused it. It shows both on `pwr_state` and as a mismatched set of enables. The case most likely to slip is standby that wrongly stays standby after a reset command. That error shows up as `osc_en` still high where sleep demands it low. A test flag that is cleared by the wrong byte, or left set by the right one, shows on `test_mode` in the very next cycle. The stimulus therefore walks every transition between states, in each direction, and checks the whole output vector after each byte.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

  localparam int CMD_W = 8;

  typedef enum logic [1:0] {
    ST_NORMAL  = 2'b00,
    ST_STANDBY = 2'b01,
    ST_SLEEP   = 2'b10
  } pwr_st_e;

  localparam logic [CMD_W-1:0] OP_NOP     = 8'hE3;
  localparam logic [CMD_W-1:0] OP_RESET   = 8'hE2;
  localparam logic [CMD_W-1:0] OP_RELEASE = 8'hE1;
  localparam logic [CMD_W-2:0] OP_SAVER   = 7'h54;  // 0xA8 / 0xA9, bit0 = level
  localparam logic [3:0]       OP_TEST_HI = 4'hF;

  typedef struct packed {
    logic nop;
    logic rst;
    logic saver;
    logic saver_stby;
    logic release_cmd;
    logic test;
  } cmd_dec_t;

endpackage

// File: rtl/pwr_cmd_decode.sv
module pwr_cmd_decode
  import pwr_seq_pkg::*;
#(
  parameter int W = CMD_W
) (
  input  logic         cmd_sel,
  input  logic         wr_stb,
  input  logic         rd_stb,
  input  logic [W-1:0] din,
  output logic         accept,
  output cmd_dec_t     dec
);

  localparam int HI_LSB = W - 4;

  assign accept = ~cmd_sel & wr_stb & ~rd_stb;

  always_comb begin
    dec             = '0;
    dec.nop         = accept & (din == OP_NOP);
    dec.rst         = accept & (din == OP_RESET);
    dec.release_cmd = accept & (din == OP_RELEASE);
    dec.saver       = accept & (din[W-1:1] == OP_SAVER);
    dec.saver_stby  = din[0];
    dec.test        = accept & (din[W-1:HI_LSB] == OP_TEST_HI);
  end

endmodule

// File: rtl/pwr_mode_fsm.sv
module pwr_mode_fsm
  import pwr_seq_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     accept,
  input  cmd_dec_t dec,
  output pwr_st_e  st_q,
  output logic     test_q
);

  pwr_st_e st_nx;
  logic    test_nx;
  logic    upd;

  assign upd = accept;

  always_comb begin
    st_nx   = st_q;
    test_nx = test_q;
    if (dec.saver) begin
      st_nx = dec.saver_stby ? ST_STANDBY : ST_SLEEP;
    end else if (dec.release_cmd) begin
      st_nx = ST_NORMAL;
    end else if (dec.rst) begin
      if (st_q == ST_STANDBY) st_nx = ST_SLEEP;
    end
    if (dec.test) begin
      test_nx = 1'b1;
    end else if (dec.nop || dec.rst) begin
      test_nx = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_NORMAL;
      test_q <= 1'b0;
    end else if (upd) begin
      st_q   <= st_nx;
      test_q <= test_nx;
    end
  end

endmodule

// File: rtl/pwr_out_map.sv
module pwr_out_map
  import pwr_seq_pkg::*;
(
  input  pwr_st_e st,
  input  logic    supply_req,
  input  logic    static_cfg,
  output logic    osc_en,
  output logic    supply_en,
  output logic    duty_en,
  output logic    static_en,
  output logic    force_vdd,
  output logic    disp_off_n
);

  always_comb begin
    osc_en     = 1'b0;
    supply_en  = 1'b0;
    duty_en    = 1'b0;
    static_en  = 1'b0;
    force_vdd  = 1'b1;
    disp_off_n = 1'b0;
    unique case (st)
      ST_NORMAL: begin
        osc_en     = 1'b1;
        supply_en  = supply_req;
        duty_en    = 1'b1;
        static_en  = static_cfg;
        force_vdd  = 1'b0;
        disp_off_n = 1'b1;
      end
      ST_STANDBY: begin
        osc_en    = 1'b1;
        static_en = static_cfg;
      end
      default: begin
      end
    endcase
  end

endmodule

// File: rtl/lcd_pwr_seq.sv
module lcd_pwr_seq
  import pwr_seq_pkg::*;
#(
  parameter int W      = CMD_W,
  parameter int SYNC_N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_sel,
  input  logic         wr_stb,
  input  logic         rd_stb,
  input  logic [W-1:0] din,
  input  logic         supply_req,
  input  logic         static_cfg,
  output logic [1:0]   pwr_state,
  output logic         test_mode,
  output logic         osc_en,
  output logic         supply_en,
  output logic         duty_en,
  output logic         static_en,
  output logic         force_vdd,
  output logic         disp_off_n
);

  logic [SYNC_N-1:0] rst_pipe;
  logic              rst_sync_n;
  logic              accept;
  cmd_dec_t          dec;
  pwr_st_e           st_q;
  logic              test_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_N-2:0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[SYNC_N-1];

  pwr_cmd_decode #(.W(W)) u_dec (
    .cmd_sel (cmd_sel),
    .wr_stb  (wr_stb),
    .rd_stb  (rd_stb),
    .din     (din),
    .accept  (accept),
    .dec     (dec)
  );

  pwr_mode_fsm u_fsm (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .accept (accept),
    .dec    (dec),
    .st_q   (st_q),
    .test_q (test_q)
  );

  pwr_out_map u_map (
    .st         (st_q),
    .supply_req (supply_req),
    .static_cfg (static_cfg),
    .osc_en     (osc_en),
    .supply_en  (supply_en),
    .duty_en    (duty_en),
    .static_en  (static_en),
    .force_vdd  (force_vdd),
    .disp_off_n (disp_off_n)
  );

  assign pwr_state = st_q;
  assign test_mode = test_q;

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk (
  input logic       clk,
  input logic       rst_ok,
  input logic       cmd_sel,
  input logic       wr_stb,
  input logic       rd_stb,
  input logic [7:0] din,
  input logic [1:0] pwr_state,
  input logic       test_mode,
  input logic       osc_en,
  input logic       supply_en,
  input logic       duty_en,
  input logic       force_vdd,
  input logic       disp_off_n
);

  logic cmd_ok;
  assign cmd_ok = !cmd_sel && wr_stb && !rd_stb;

  p_rd_blocks_r1: assert property (@(posedge clk) disable iff (!rst_ok)
    (wr_stb && rd_stb) |=> ($stable(pwr_state) && $stable(test_mode)));

  p_data_ignored_r1: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd_sel && wr_stb) |=> ($stable(pwr_state) && $stable(test_mode)));

  p_saver_dof_r3: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd_ok && din[7:1] == 7'h54) |=> (!disp_off_n && force_vdd));

  p_standby_osc_r4: assert property (@(posedge clk) disable iff (!rst_ok)
    (pwr_state == 2'b01) |-> (osc_en && !supply_en && !duty_en));

  p_sleep_halt_r5: assert property (@(posedge clk) disable iff (!rst_ok)
    (pwr_state == 2'b10) |-> (!osc_en && !supply_en && !duty_en && force_vdd));

  p_rst_deepens_r6: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd_ok && din == 8'hE2 && pwr_state == 2'b01) |=> (pwr_state == 2'b10 && !test_mode));

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd_ok && din == 8'hE1) |=> (pwr_state == 2'b00 && disp_off_n));

  p_nop_r8: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd_ok && din == 8'hE3) |=> ($stable(pwr_state) && !test_mode));

  p_test_set_r9: assert property (@(posedge clk) disable iff (!rst_ok)
    (cmd_ok && din[7:4] == 4'hF) |=> (test_mode && $stable(pwr_state)));

endmodule

bind lcd_pwr_seq pwr_seq_chk u_chk (
  .clk        (clk),
  .rst_ok     (rst_sync_n),
  .cmd_sel    (cmd_sel),
  .wr_stb     (wr_stb),
  .rd_stb     (rd_stb),
  .din        (din),
  .pwr_state  (pwr_state),
  .test_mode  (test_mode),
  .osc_en     (osc_en),
  .supply_en  (supply_en),
  .duty_en    (duty_en),
  .force_vdd  (force_vdd),
  .disp_off_n (disp_off_n)
);

// File: tb/tb_lcd_pwr_seq.sv
`timescale 1ns/1ps
module tb_lcd_pwr_seq;

  logic       clk;
  logic       rst_n;
  logic       cmd_sel, wr_stb, rd_stb;
  logic [7:0] din;
  logic       supply_req, static_cfg;
  logic [1:0] pwr_state;
  logic       test_mode, osc_en, supply_en, duty_en, static_en, force_vdd, disp_off_n;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    logic [8:0] vec;
    string      tag;
  } exp_t;
  exp_t sbq[$];

  logic [1:0] m_st;
  logic       m_test;

  lcd_pwr_seq dut (
    .clk(clk), .rst_n(rst_n), .cmd_sel(cmd_sel), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .din(din), .supply_req(supply_req), .static_cfg(static_cfg),
    .pwr_state(pwr_state), .test_mode(test_mode), .osc_en(osc_en),
    .supply_en(supply_en), .duty_en(duty_en), .static_en(static_en),
    .force_vdd(force_vdd), .disp_off_n(disp_off_n)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic logic [8:0] act_vec();
    return {pwr_state, test_mode, osc_en, supply_en, duty_en, static_en, force_vdd, disp_off_n};
  endfunction

  // {state, test, osc, supply, duty, static, force, dof_n} from R2/R4/R5
  function automatic logic [8:0] model(logic [1:0] st, logic t, logic sup, logic sta);
    case (st)
      2'b00:   return {st, t, 1'b1, sup,  1'b1, sta,  1'b0, 1'b1};
      2'b01:   return {st, t, 1'b1, 1'b0, 1'b0, sta,  1'b1, 1'b0};
      default: return {st, t, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
    endcase
  endfunction

  task automatic check(logic [8:0] exp, string tag);
    logic [8:0] a;
    a = act_vec();
    checks++;
    if (a !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, a, exp);
    end
  endtask

  // Driver: one byte per cycle, model update, push expectation
  task automatic send(logic [7:0] b, logic sel, logic rd, logic sup, logic sta, string tag);
    @(negedge clk);
    din = b; cmd_sel = sel; wr_stb = 1'b1; rd_stb = rd;
    supply_req = sup; static_cfg = sta;
    if (!sel && !rd) begin
      if (b[7:1] == 7'h54)      m_st = b[0] ? 2'b01 : 2'b10;
      else if (b == 8'hE1)      m_st = 2'b00;
      else if (b == 8'hE2 && m_st == 2'b01) m_st = 2'b10;
      if (b[7:4] == 4'hF)       m_test = 1'b1;
      else if (b == 8'hE3 || b == 8'hE2) m_test = 1'b0;
    end
    sbq.push_back('{model(m_st, m_test, sup, sta), tag});
    @(negedge clk);
    wr_stb = 1'b0; rd_stb = 1'b0; cmd_sel = 1'b0;
  endtask

  // Monitor: one posedge after the byte, sample 1 ns later
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        exp_t e;
        e = sbq.pop_front();
        check(e.vec, e.tag);
      end
    end
  end

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cmd_sel = 1'b0; wr_stb = 1'b0; rd_stb = 1'b0; din = 8'h00;
    supply_req = 1'b0; static_cfg = 1'b0;
    m_st = 2'b00; m_test = 1'b0;
    #1;
    check(model(2'b00, 1'b0, 1'b0, 1'b0), "R10 reset state");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    send(8'hE3, 0, 0, 1, 1, "R2 normal supply/static follow config");
    send(8'h40, 0, 0, 0, 1, "R1 unknown command ignored");
    send(8'hA9, 0, 0, 1, 1, "R3/R4 enter standby");
    send(8'hE3, 0, 0, 1, 0, "R4 standby static follows config");
    send(8'hE2, 0, 0, 1, 1, "R6 reset command standby->sleep");
    send(8'hE3, 0, 0, 1, 1, "R5 sleep outputs, R8 NOP keeps sleep");
    send(8'hE2, 0, 0, 1, 1, "R6 reset command keeps sleep");
    send(8'hE1, 0, 0, 1, 1, "R7 release from sleep");
    send(8'hE2, 0, 0, 1, 1, "R6 reset command keeps normal");
    send(8'hA8, 0, 0, 1, 1, "R3 enter sleep from normal");
    send(8'hA9, 0, 0, 1, 1, "R3 sleep->standby by saver command");
    send(8'hF5, 0, 0, 1, 1, "R9 test set in standby");
    send(8'hE3, 0, 0, 1, 1, "R8 NOP clears test, keeps standby");
    send(8'hE1, 0, 0, 1, 1, "R7 release from standby");
    send(8'hF0, 0, 0, 1, 1, "R9 test set low nibble 0");
    send(8'hE2, 0, 0, 1, 1, "R6 reset command clears test");
    send(8'hA8, 1, 0, 1, 1, "R1 data byte ignored");
    send(8'hA8, 0, 1, 1, 1, "R1 read blocks command");
    send(8'hFF, 0, 0, 0, 0, "R9 test set low nibble F");

    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check(model(2'b00, 1'b0, 1'b0, 1'b0), "R10 hardware reset clears test");
    m_st = 2'b00; m_test = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    send(8'hA9, 0, 0, 0, 1, "R3 standby after hardware reset");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule